// File: doc/BRIEF.md
# PIO Cycle Timing Engine for a Parallel ATA Host

This block performs one programmed-I/O access at a time on a parallel ATA bus. A requester presents a direction flag, a five-bit register select, a flag choosing register timing or data-port timing, and write data. The engine drives the chip selects and the three address lines, runs a setup phase, pulls exactly one of the active-low read/write strobes, optionally stretches that strobe while the drive holds IORDY low, and then waits out a recovery interval before it takes another request. Read data is latched from the bus when the read strobe is released and returned with a one-cycle done pulse.

All phase lengths are counted in clock ticks supplied on configuration inputs. There are separate active, cycle and minimum-recovery counts for 8-bit register accesses and for 16-bit data accesses. The setup count is shared. Write data stays driven for a short hold after the write strobe rises, and the hold length depends on the programmed PIO mode. The recovery phase is never shorter than that hold, so the bus is always released before the next access.

The controller is a five-state machine. IDLE moves to SETUP when a request arrives. SETUP moves to ACTIVE when the setup count runs out. ACTIVE moves to WAIT when its count runs out while IORDY checking is on, IORDY is low and wait budget remains. Otherwise ACTIVE moves to RECOVER. WAIT moves to RECOVER on IORDY high or when the wait budget is spent. RECOVER moves back to IDLE when the recovery count runs out.

Top module: `pata_pio_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, both chip selects and both strobes are high, the address lines are 0 and busy and done are low.
- R2: Throughout an access the register select drives the pins: bits [4:2] go to address lines A2..A0, bit 1 to CS1N and bit 0 to CS0N (for example, 5'b01010 selects address 2 with CS1N high and CS0N low, and 5'b11001 selects address 6 with CS0N high and CS1N low).
- R3: After acceptance both strobes stay high with the address driven for max(setup, 1) cycles.
- R4: Exactly one strobe goes low during an access: DIOR for a read (write flag 0) and DIOW for a write (write flag 1). The two strobes are never low together.
- R5: The strobe stays low for max(active, 1) cycles taken from the register set when the wide flag is 0 and from the data set when the wide flag is 1, unless R6 extends it.
- R6: With IORDY checking on, if IORDY is low in the last active cycle, the strobe stays low until a cycle ends with IORDY high. The total low time is capped at 51 cycles ((1250+35)/25). An active count of 51 or more gets no extension. With checking off, IORDY has no effect.
- R7: Recovery (strobe high up to and including the done cycle) lasts the larger of (cycle count minus total low cycles, floored at 0) and the minimum recovery count. It is further raised to at least the write hold count and at least 1.
- R8: A read returns the value on the data pins in the last cycle before DIOR rises, and that value remains on the read-data output afterwards.
- R9: A write drives the data pins with the write data, with output enable high, in every cycle DIOW is low and for H more cycles after it rises: H=3 in PIO mode 0, H=2 in modes 1 and 2, and H=1 in modes 3 and above.
- R10: Done is a single-cycle pulse in the final recovery cycle. Busy is high from the cycle after acceptance through the done cycle. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_regsel | input | 5 | {A2..A0, CS1N, CS0N} pin levels for the access |
| req_wide | input | 1 | 1 = data-port timing set, 0 = register timing set |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | 8 | Setup ticks |
| cfg_act8 | input | 8 | Register active ticks |
| cfg_cyc8 | input | 8 | Register cycle ticks |
| cfg_rec8 | input | 8 | Register minimum recovery ticks |
| cfg_act16 | input | 8 | Data active ticks |
| cfg_cyc16 | input | 8 | Data cycle ticks |
| cfg_rec16 | input | 8 | Data minimum recovery ticks |
| cfg_pio_mode | input | 3 | PIO mode number, selects the write hold |
| cfg_iordy_en | input | 1 | Enables IORDY stretching |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final-cycle pulse of an access |
| rdata | output | 16 | Last read result |
| ata_cs0n | output | 1 | Chip select 0, active low |
| ata_cs1n | output | 1 | Chip select 1, active low |
| ata_addr | output | 3 | Address lines A2..A0 |
| ata_diorn | output | 1 | Read strobe, active low |
| ata_diown | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data driven to the bus |
| ata_dd_oe | output | 1 | Data output enable |
| ata_dd_in | input | 16 | Data sampled from the bus |
| ata_iordy | input | 1 | Drive ready |

## Verification
The bench targets these corner cases:
- The IORDY wait that never ends. A missing cap would hang the strobe, and an off-by-one cap would give 50 or 52 low cycles instead of 51.
- An active count at or above the cap, which must not be stretched.
- A cycle count shorter than the stretched low time, where a design that subtracts without flooring would wrap to a huge recovery.
- A mode-0 write whose minimum recovery is shorter than the three-cycle hold, which would otherwise let done arrive while data is still driven.
- Swapped timing sets, and zero setup or recovery counts that a naive counter would turn into 256-cycle phases.
- The read bus changes every cycle, so a capture one edge early or late returns the wrong word.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_WAIT,
        ST_RECOVER
    } pio_state_t;

endpackage

// File: rtl/pata_pio_hold_sel.sv
module pata_pio_hold_sel #(
    parameter int MW = 3,
    parameter int HW = 2
) (
    input  logic [MW-1:0] mode,
    output logic [HW-1:0] hold
);
    // Slower modes need the bus held longer after the write strobe rises.
    always_comb begin
        if (mode == '0)
            hold = HW'(3);
        else if (mode < MW'(3))
            hold = HW'(2);
        else
            hold = HW'(1);
    end
endmodule

// File: rtl/pata_pio_recovery.sv
module pata_pio_recovery #(
    parameter int TW = 8,
    parameter int HW = 2,
    localparam int CW = TW + 1
) (
    input  logic [CW-1:0] low_cycles,
    input  logic [TW-1:0] cyc_ticks,
    input  logic [TW-1:0] rec_min,
    input  logic [HW-1:0] hold,
    output logic [CW-1:0] rec_ticks
);
    logic [CW-1:0] cyc_w, remain, pick, held;

    always_comb begin
        cyc_w  = CW'(cyc_ticks);
        remain = (cyc_w > low_cycles) ? (cyc_w - low_cycles) : '0;
        pick   = (remain > CW'(rec_min)) ? remain : CW'(rec_min);
        held   = (pick > CW'(hold)) ? pick : CW'(hold);
        rec_ticks = (held == '0) ? CW'(1) : held;
    end
endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
    import pata_pio_pkg::*;
#(
    parameter int TW      = 8,
    parameter int DW      = 16,
    parameter int MW      = 3,
    parameter int TA_NS   = 35,
    parameter int TB_NS   = 1250,
    parameter int TICK_NS = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [4:0]    req_regsel,
    input  logic          req_wide,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_act8,
    input  logic [TW-1:0] cfg_cyc8,
    input  logic [TW-1:0] cfg_rec8,
    input  logic [TW-1:0] cfg_act16,
    input  logic [TW-1:0] cfg_cyc16,
    input  logic [TW-1:0] cfg_rec16,
    input  logic [MW-1:0] cfg_pio_mode,
    input  logic          cfg_iordy_en,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          ata_cs0n,
    output logic          ata_cs1n,
    output logic [2:0]    ata_addr,
    output logic          ata_diorn,
    output logic          ata_diown,
    output logic [DW-1:0] ata_dd_out,
    output logic          ata_dd_oe,
    input  logic [DW-1:0] ata_dd_in,
    input  logic          ata_iordy
);
    localparam int CW  = TW + 1;
    localparam int HW  = 2;
    localparam int CAP = (TB_NS + TA_NS) / TICK_NS;
    localparam logic [CW-1:0] CAP_V = CW'(CAP);

    pio_state_t    state, state_n;
    logic [CW-1:0] cnt, el, wcnt;
    logic [HW-1:0] hold_cnt;
    logic          lat_write, lat_wide;
    logic [4:0]    lat_sel;
    logic [DW-1:0] lat_wdata, rdata_q;

    logic [TW-1:0] act_sel, cyc_sel, rec_sel;
    logic [CW-1:0] act_eff, wait_lim, low_total, rec_ticks;
    logic [HW-1:0] hold_mode, hold_apply;
    logic          strobe_low;

    // Timing set chosen by access width
    always_comb begin
        act_sel    = lat_wide ? cfg_act16 : cfg_act8;
        cyc_sel    = lat_wide ? cfg_cyc16 : cfg_cyc8;
        rec_sel    = lat_wide ? cfg_rec16 : cfg_rec8;
        act_eff    = (act_sel == '0) ? CW'(1) : CW'(act_sel);
        wait_lim   = (act_eff >= CAP_V) ? '0 : (CAP_V - act_eff);
        low_total  = el + CW'(1);
        hold_apply = lat_write ? hold_mode : '0;
    end

    pata_pio_hold_sel #(.MW(MW), .HW(HW)) u_hold (
        .mode (cfg_pio_mode),
        .hold (hold_mode)
    );

    pata_pio_recovery #(.TW(TW), .HW(HW)) u_recov (
        .low_cycles (low_total),
        .cyc_ticks  (cyc_sel),
        .rec_min    (rec_sel),
        .hold       (hold_apply),
        .rec_ticks  (rec_ticks)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_n = ST_SETUP;
            ST_SETUP:   if (cnt <= CW'(1)) state_n = ST_ACTIVE;
            ST_ACTIVE:  if (cnt <= CW'(1))
                            state_n = (cfg_iordy_en && !ata_iordy && wait_lim != '0)
                                      ? ST_WAIT : ST_RECOVER;
            ST_WAIT:    if (ata_iordy || (wcnt + CW'(1)) >= wait_lim) state_n = ST_RECOVER;
            ST_RECOVER: if (cnt <= CW'(1)) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Counters and latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            el        <= '0;
            wcnt      <= '0;
            hold_cnt  <= '0;
            lat_write <= 1'b0;
            lat_wide  <= 1'b0;
            lat_sel   <= 5'b00011;
            lat_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    lat_write <= req_write;
                    lat_wide  <= req_wide;
                    lat_sel   <= req_regsel;
                    lat_wdata <= req_wdata;
                    cnt       <= CW'(cfg_setup);
                end
                ST_SETUP: begin
                    if (cnt <= CW'(1)) begin
                        cnt <= CW'(act_sel);
                        el  <= '0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_ACTIVE: begin
                    el   <= el + CW'(1);
                    wcnt <= '0;
                    if (cnt > CW'(1)) cnt <= cnt - CW'(1);
                end
                ST_WAIT: begin
                    el   <= el + CW'(1);
                    wcnt <= wcnt + CW'(1);
                end
                ST_RECOVER: begin
                    if (cnt != '0)      cnt      <= cnt - CW'(1);
                    if (hold_cnt != '0) hold_cnt <= hold_cnt - HW'(1);
                end
                default: ;
            endcase
            // Strobe release: load recovery, start hold, capture read data
            if (state_n == ST_RECOVER && state != ST_RECOVER) begin
                cnt      <= rec_ticks;
                hold_cnt <= hold_apply;
                if (!lat_write) rdata_q <= ata_dd_in;
            end
        end
    end

    // Outputs
    always_comb begin
        strobe_low = (state == ST_ACTIVE) || (state == ST_WAIT);
        busy       = (state != ST_IDLE);
        done       = (state == ST_RECOVER) && (cnt <= CW'(1));
        ata_cs0n   = busy ? lat_sel[0] : 1'b1;
        ata_cs1n   = busy ? lat_sel[1] : 1'b1;
        ata_addr   = busy ? lat_sel[4:2] : 3'd0;
        ata_diorn  = !(strobe_low && !lat_write);
        ata_diown  = !(strobe_low && lat_write);
        ata_dd_oe  = (strobe_low && lat_write) || (hold_cnt != '0);
        ata_dd_out = ata_dd_oe ? lat_wdata : '0;
        rdata      = rdata_q;
    end

    // Assertions
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_diorn && !ata_diown));

    assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ata_diorn) || $fell(ata_diown)) |-> ($past(busy) && $past(ata_diorn) && $past(ata_diown)));

    assert_wait_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (el < CAP_V));

    assert_hold_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_diown) |-> ata_dd_oe);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy && !done) |-> busy);

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ata_addr) && $stable(ata_cs0n) && $stable(ata_cs1n)));

endmodule

// File: tb/pata_pio_engine_tb.sv
module pata_pio_engine_tb;

    typedef struct packed {
        logic       wr;
        logic       wide;
        logic [4:0] rs;
        logic [7:0] s;
        logic [7:0] a8;
        logic [7:0] c8;
        logic [7:0] r8;
        logic [7:0] a16;
        logic [7:0] c16;
        logic [7:0] r16;
        logic       en;
        logic [7:0] k;
        logic [2:0] mode;
        logic [15:0] wd;
    } vec_t;

    // k = 0: IORDY high throughout; otherwise IORDY rises after low cycle k
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 5'b01010, 8'd2, 8'd4,  8'd12, 8'd3, 8'd9,  8'd30, 8'd7,  1'b0, 8'd0,   3'd0, 16'h0000},
        '{1'b1, 1'b0, 5'b11001, 8'd1, 8'd3,  8'd5,  8'd4, 8'd11, 8'd25, 8'd9,  1'b0, 8'd0,   3'd1, 16'hA55A},
        '{1'b0, 1'b1, 5'b00010, 8'd3, 8'd2,  8'd3,  8'd1, 8'd6,  8'd20, 8'd2,  1'b1, 8'd10,  3'd2, 16'h0000},
        '{1'b1, 1'b1, 5'b00010, 8'd0, 8'd9,  8'd9,  8'd9, 8'd2,  8'd4,  8'd0,  1'b1, 8'd0,   3'd4, 16'h1234},
        '{1'b1, 1'b0, 5'b11110, 8'd2, 8'd5,  8'd6,  8'd1, 8'd12, 8'd40, 8'd8,  1'b0, 8'd0,   3'd0, 16'hBEEF},
        '{1'b0, 1'b0, 5'b01110, 8'd1, 8'd10, 8'd40, 8'd2, 8'd3,  8'd5,  8'd6,  1'b1, 8'd255, 3'd3, 16'h0000},
        '{1'b0, 1'b0, 5'b10010, 8'd1, 8'd60, 8'd70, 8'd5, 8'd4,  8'd8,  8'd2,  1'b1, 8'd255, 3'd3, 16'h0000},
        '{1'b0, 1'b1, 5'b00010, 8'd2, 8'd15, 8'd30, 8'd9, 8'd7,  8'd9,  8'd1,  1'b0, 8'd255, 3'd3, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [4:0]  req_regsel = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  cfg_setup = 8'd1, cfg_act8 = 8'd1, cfg_cyc8 = 8'd1, cfg_rec8 = 8'd1;
    logic [7:0]  cfg_act16 = 8'd1, cfg_cyc16 = 8'd1, cfg_rec16 = 8'd1;
    logic [2:0]  cfg_pio_mode = '0;
    logic        cfg_iordy_en = 1'b0;
    logic        busy, done;
    logic [15:0] rdata, ata_dd_out;
    logic        ata_cs0n, ata_cs1n, ata_diorn, ata_diown, ata_dd_oe;
    logic [2:0]  ata_addr;
    logic [15:0] ata_dd_in = '0;
    logic        ata_iordy = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pata_pio_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_regsel(req_regsel),
        .req_wide(req_wide), .req_wdata(req_wdata),
        .cfg_setup(cfg_setup), .cfg_act8(cfg_act8), .cfg_cyc8(cfg_cyc8), .cfg_rec8(cfg_rec8),
        .cfg_act16(cfg_act16), .cfg_cyc16(cfg_cyc16), .cfg_rec16(cfg_rec16),
        .cfg_pio_mode(cfg_pio_mode), .cfg_iordy_en(cfg_iordy_en),
        .busy(busy), .done(done), .rdata(rdata),
        .ata_cs0n(ata_cs0n), .ata_cs1n(ata_cs1n), .ata_addr(ata_addr),
        .ata_diorn(ata_diorn), .ata_diown(ata_diown),
        .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
        .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_vec(input vec_t v);
        int setup_c = 0, low_c = 0, rec_c = 0, hold_c = 0, guard = 0, phase = 0;
        int a, c, r, h, e_low, e_rec;
        bit other_bad = 0, data_bad = 0, pin_bad = 0, early_done = 0, seen = 0;
        logic sl, so;
        logic [15:0] rd = '0;
        a = v.wide ? int'(v.a16) : int'(v.a8);
        c = v.wide ? int'(v.c16) : int'(v.c8);
        r = v.wide ? int'(v.r16) : int'(v.r8);
        a = mx(a, 1);
        h = !v.wr ? 0 : (v.mode == 0) ? 3 : (v.mode < 3) ? 2 : 1;
        if (!v.en || v.k == 0 || a >= 51) e_low = a;
        else e_low = (mx(int'(v.k), a) < 51) ? mx(int'(v.k), a) : 51;
        e_rec = mx(mx(mx((c > e_low) ? c - e_low : 0, r), h), 1);

        @(negedge clk);
        cfg_setup = v.s; cfg_act8 = v.a8; cfg_cyc8 = v.c8; cfg_rec8 = v.r8;
        cfg_act16 = v.a16; cfg_cyc16 = v.c16; cfg_rec16 = v.r16;
        cfg_iordy_en = v.en; cfg_pio_mode = v.mode;
        ata_iordy = (v.k == 0);
        ata_dd_in = 16'h1111;
        req_valid = 1'b1; req_write = v.wr; req_wide = v.wide;
        req_regsel = v.rs; req_wdata = v.wd;
        @(posedge clk); #1 req_valid = 1'b0;
        while (!seen && guard < 600) begin
            @(negedge clk);
            guard++;
            sl = v.wr ? !ata_diown : !ata_diorn;
            so = v.wr ? !ata_diorn : !ata_diown;
            if (so) other_bad = 1;
            if ({ata_addr, ata_cs1n, ata_cs0n} != v.rs) pin_bad = 1;
            case (phase)
                0: if (sl) begin phase = 1; low_c = 1; end else setup_c++;
                1: if (sl) low_c++; else begin phase = 2; rec_c = 1; end
                default: begin rec_c++; if (sl) other_bad = 1; end
            endcase
            if (done && phase != 2) early_done = 1;
            if (phase == 1) begin
                if (v.wr && (!ata_dd_oe || ata_dd_out != v.wd)) data_bad = 1;
                ata_dd_in = 16'h3C00 + 16'(low_c);
                if (v.k != 0 && low_c >= int'(v.k)) ata_iordy = 1'b1;
            end
            if (phase == 2) begin
                if (ata_dd_oe) hold_c++;
                ata_dd_in = 16'hDEAD;
                if (done) begin seen = 1; rd = rdata; end
            end
        end
        chk("R10 access completes", int'(seen), 1);
        chk("R10 no done before recovery", int'(early_done), 0);
        chk("R2 select pins", int'(pin_bad), 0);
        chk("R4 other strobe idle", int'(other_bad), 0);
        chk("R3 setup cycles", setup_c, mx(int'(v.s), 1));
        chk("R5/R6 low cycles", low_c, e_low);
        chk("R7 recovery cycles", rec_c, e_rec);
        chk("R9 hold cycles", hold_c, h);
        if (v.wr) chk("R9 data while DIOW low", int'(data_bad), 0);
        else      chk("R8 read capture", int'(rd), int'(16'h3C00 + 16'(e_low)));
        @(negedge clk);
        chk("R10 busy drops after done", int'(busy), 0);
        chk("R1 idle pins", int'({ata_cs0n, ata_cs1n, ata_diorn, ata_diown}), 15);
        if (!v.wr) chk("R8 read data held", int'(rdata), int'(16'h3C00 + 16'(e_low)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        bit stray;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset pins", int'({ata_cs0n, ata_cs1n, ata_diorn, ata_diown}), 15);
        chk("R1 reset addr", int'(ata_addr), 0);
        chk("R1 reset busy/done", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: requests while busy are ignored
        @(negedge clk);
        cfg_setup = 8'd2; cfg_act8 = 8'd3; cfg_cyc8 = 8'd4; cfg_rec8 = 8'd2;
        cfg_iordy_en = 1'b0; ata_iordy = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b0; req_regsel = 5'b01010;
        @(posedge clk); #1 req_regsel = 5'b11001; req_write = 1'b1;
        stray = 0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            if (ata_addr != 3'd2 || !ata_diown) stray = 1;
        end
        req_valid = 1'b0;
        chk("R10 busy request ignored", int'(stray), 0);
        for (int j = 0; j < 20 && !done; j++) @(negedge clk);
        chk("R10 done seen", int'(done), 1);
        repeat (2) @(negedge clk);
        chk("R10 no second access", int'({busy, ata_cs0n, ata_cs1n}), 3);

        // R1: reset in the middle of an access
        req_valid = 1'b1; req_write = 1'b1; req_regsel = 5'b01010;
        @(posedge clk); #1 req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 write strobe low mid-access", int'(ata_diown), 0);
        rst_n = 1'b0;
        #1;
        chk("R1 pins after reset mid-access", int'({ata_cs0n, ata_cs1n, ata_diorn, ata_diown, ata_dd_oe}), 30);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule